// File: doc/BRIEF.md
# Keyboard Controller Command Engine

This block sits behind the command and data ports of a legacy PC keyboard/mouse controller. It takes each byte the host writes to the command port, decodes it and carries it out. Three read commands copy the pin inputs, the stored output-port byte or the clock-line test inputs into the controller's output buffer. Two commands arm the engine so that the next byte written to the data port is either stored in the output port or handed to the mouse transmitter. A range of pulse commands drives selected output-port lines low for a fixed interval, for example to request a CPU reset.

The host side is a single write strobe with a command/data select and a byte. Results go out through a one-cycle load strobe toward the output buffer. That buffer reports when it is still full, and the engine then holds the result back. A `busy` flag covers every operation that takes more than the accepting cycle. Host writes that arrive while `busy` is high are dropped.

Top module: `kbc_cmd_engine`

## Requirements
- R1: Command C0h loads the byte {inhibit pin, 5'b0, mouse data pin, keyboard data pin} (bit 7 down to bit 0), sampled in the accepting cycle, into the output buffer. With the buffer empty, `ob_load` is high in the cycle after the write.
- R2: Command D0h loads the stored output-port byte into the output buffer. Only bits 5 (mouse IRQ), 4 (keyboard IRQ), 1 (gate A20) and 0 (reset request, active low) are live; bits 7:6 and 3:2 read 0.
- R3: Command E0h loads {6'b0, mouse clock pin, keyboard clock pin} into the output buffer.
- R4: While `obf_full` is high a pending read result is held and `ob_load` stays low. `ob_load` rises for exactly one cycle in the first cycle `obf_full` is low.
- R5: After command D1h, the next data-port byte is stored into the output port, keeping only bits 5, 4, 1 and 0. `out_port` bits 7:6 and 3:2 are always 0.
- R6: After command D4h, the next data-port byte appears on `ms_tx_data` with `ms_tx_req` high from the following cycle. Both hold, and `busy` stays high, until a cycle with `ms_tx_done` high.
- R7: A command F0h–FFh whose bit 0 and/or bit 1 is 0 drives the matching `out_port` bit low for exactly `PULSE_CYC` cycles, starting the cycle after the write. `busy` is high for those cycles. Command bits 2 and 3 have no effect.
- R8: A command in F0h–FFh with bits 1:0 both 1 (including FFh) completes in its accepting cycle. It sets no busy and changes no output.
- R9: Any command written while a D1h or D4h data byte is pending cancels the pending state and is then decoded on its own.
- R10: Unrecognised opcodes, and data-port bytes with nothing pending, change neither the output port, the output buffer nor the mouse interface.
- R11: Host writes accepted while `busy` is high are ignored.
- R12: After reset, `out_port` equals `OUTP_INIT` masked to the live bits (default 03h), and `busy`, `ob_load` and `ms_tx_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | One-cycle host write strobe |
| host_is_cmd | input | 1 | 1: command port, 0: data port |
| host_wdata | input | 8 | Byte written by the host |
| obf_full | input | 1 | Output buffer still holds an unread byte |
| ob_load | output | 1 | Load strobe toward the output buffer |
| ob_data | output | 8 | Byte to load, valid with `ob_load` |
| kb_inhibit_in | input | 1 | Keyboard inhibit pin |
| kb_data_in | input | 1 | Keyboard data line |
| ms_data_in | input | 1 | Mouse data line |
| kb_clk_in | input | 1 | Keyboard clock line |
| ms_clk_in | input | 1 | Mouse clock line |
| out_port | output | 8 | Output port as driven, pulses applied |
| ms_tx_req | output | 1 | Byte waiting for the mouse transmitter |
| ms_tx_data | output | 8 | Byte for the mouse transmitter |
| ms_tx_done | input | 1 | Mouse transmitter finished |
| busy | output | 1 | Engine occupied; host writes dropped |

## Verification
The bench measures the pulse width cycle by cycle, because a counter that is off by one shortens the reset request below its minimum. It writes a new command between an arming command and its data byte. A design that failed to cancel would then store a stray byte in the output port or send it to the mouse. A read is issued against a full output buffer, because a design that loads anyway overwrites a byte the host has not yet read. The bench also sends the no-pulse opcodes and writes during a pulse: a wrong design would either raise `busy` for nothing or let a dropped write arm the engine.

// File: rtl/kbc_pkg.sv
`timescale 1ns/1ps
package kbc_pkg;

  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned PULSE_W = 2;   // output-port bits reachable by a pulse

  localparam logic [BYTE_W-1:0] OP_RD_PINS  = 8'hC0;
  localparam logic [BYTE_W-1:0] OP_RD_PORT  = 8'hD0;
  localparam logic [BYTE_W-1:0] OP_WR_PORT  = 8'hD1;
  localparam logic [BYTE_W-1:0] OP_TO_MOUSE = 8'hD4;
  localparam logic [BYTE_W-1:0] OP_RD_CLKS  = 8'hE0;
  localparam logic [3:0]        OP_PULSE_HI = 4'hF;

  // live output-port bits: mouse irq, keyboard irq, gate A20, reset request
  localparam logic [BYTE_W-1:0] PORT_LIVE = 8'h33;

  typedef enum logic [1:0] {
    ARM_NONE,
    ARM_PORT,
    ARM_MOUSE
  } arm_e;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_RD_PINS,
    ACT_RD_PORT,
    ACT_RD_CLKS,
    ACT_ARM_PORT,
    ACT_ARM_MOUSE,
    ACT_PULSE
  } act_e;

endpackage

// File: rtl/kbc_rst_sync.sv
`timescale 1ns/1ps
module kbc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_n;

  always_comb begin
    sh_n = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_n;
  end

  assign rst_sync_n = sh_q[STAGES-1];

endmodule

// File: rtl/kbc_cmd_decode.sv
`timescale 1ns/1ps
module kbc_cmd_decode
  import kbc_pkg::*;
(
  input  logic [BYTE_W-1:0]  opcode,
  output act_e               act,
  output logic [PULSE_W-1:0] pulse_sel
);

  always_comb begin
    act       = ACT_NONE;
    pulse_sel = '0;
    if (opcode[BYTE_W-1:BYTE_W-4] == OP_PULSE_HI) begin
      // a 0 in a command bit selects that port bit; bits above PULSE_W are unused
      pulse_sel = ~opcode[PULSE_W-1:0];
      act       = (|pulse_sel) ? ACT_PULSE : ACT_NONE;
    end else begin
      case (opcode)
        OP_RD_PINS:  act = ACT_RD_PINS;
        OP_RD_PORT:  act = ACT_RD_PORT;
        OP_RD_CLKS:  act = ACT_RD_CLKS;
        OP_WR_PORT:  act = ACT_ARM_PORT;
        OP_TO_MOUSE: act = ACT_ARM_MOUSE;
        default:     act = ACT_NONE;
      endcase
    end
  end

endmodule

// File: rtl/kbc_pulse_timer.sv
`timescale 1ns/1ps
module kbc_pulse_timer #(
  parameter int unsigned PULSE_CYC = 1500,
  parameter int unsigned NB        = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NB-1:0] start_sel,
  output logic          active,
  output logic [NB-1:0] low_sel
);

  localparam int unsigned CW = $clog2(PULSE_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic [NB-1:0] sel_q, sel_n;
  logic          cnt_en;

  always_comb begin
    cnt_n  = cnt_q;
    sel_n  = sel_q;
    cnt_en = 1'b0;
    if (start) begin
      cnt_en = 1'b1;
      cnt_n  = CW'(PULSE_CYC);
      sel_n  = start_sel;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_n  = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) sel_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sel_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_n;
      sel_q <= sel_n;
    end
  end

  assign active  = (cnt_q != '0);
  assign low_sel = sel_q;

endmodule

// File: rtl/kbc_read_stage.sv
`timescale 1ns/1ps
module kbc_read_stage #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [DW-1:0] cap_data,
  input  logic          obf_full,
  output logic          pending,
  output logic          ob_load,
  output logic [DW-1:0] ob_data
);

  logic          pend_q, pend_n;
  logic [DW-1:0] data_q;

  always_comb begin
    pend_n = pend_q;
    if (capture)                pend_n = 1'b1;
    else if (pend_q && !obf_full) pend_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (capture) data_q <= cap_data;
  end

  assign pending = pend_q;
  assign ob_load = pend_q & ~obf_full;
  assign ob_data = data_q;

endmodule

// File: rtl/kbc_mouse_fwd.sv
`timescale 1ns/1ps
module kbc_mouse_fwd #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          send,
  input  logic [DW-1:0] send_data,
  input  logic          tx_done,
  output logic          tx_req,
  output logic [DW-1:0] tx_data
);

  logic          req_q, req_n;
  logic [DW-1:0] dat_q;

  always_comb begin
    req_n = req_q;
    if (send)                req_n = 1'b1;
    else if (req_q && tx_done) req_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dat_q <= '0;
    else if (send) dat_q <= send_data;
  end

  assign tx_req  = req_q;
  assign tx_data = dat_q;

endmodule

// File: rtl/kbc_cmd_engine.sv
`timescale 1ns/1ps
module kbc_cmd_engine
  import kbc_pkg::*;
#(
  parameter int unsigned       PULSE_CYC = 1500,   // >= 6 us at 250 MHz
  parameter logic [BYTE_W-1:0] OUTP_INIT = 8'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_is_cmd,
  input  logic [BYTE_W-1:0] host_wdata,
  input  logic              obf_full,
  output logic              ob_load,
  output logic [BYTE_W-1:0] ob_data,
  input  logic              kb_inhibit_in,
  input  logic              kb_data_in,
  input  logic              ms_data_in,
  input  logic              kb_clk_in,
  input  logic              ms_clk_in,
  output logic [BYTE_W-1:0] out_port,
  output logic              ms_tx_req,
  output logic [BYTE_W-1:0] ms_tx_data,
  input  logic              ms_tx_done,
  output logic              busy
);

  localparam logic [BYTE_W-1:0] PORT_RST = OUTP_INIT & PORT_LIVE;

  logic               rst_i_n;
  act_e               act;
  logic [PULSE_W-1:0] pulse_sel;
  logic [PULSE_W-1:0] low_sel;
  logic               pulse_active;
  logic               rd_pending;
  logic               cmd_take, dat_take, rd_capture, pulse_start, ms_send;
  logic [BYTE_W-1:0]  cap_byte;
  arm_e               arm_q, arm_n;
  logic [BYTE_W-1:0]  port_q, port_n;
  logic               state_en;

  kbc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  kbc_cmd_decode u_dec (
    .opcode    (host_wdata),
    .act       (act),
    .pulse_sel (pulse_sel)
  );

  // writes are dropped while any operation is in flight
  assign busy        = pulse_active | rd_pending | ms_tx_req;
  assign cmd_take    = host_wr & ~busy &  host_is_cmd;
  assign dat_take    = host_wr & ~busy & ~host_is_cmd;
  assign rd_capture  = cmd_take & ((act == ACT_RD_PINS) | (act == ACT_RD_PORT) |
                                   (act == ACT_RD_CLKS));
  assign pulse_start = cmd_take & (act == ACT_PULSE);
  assign ms_send     = dat_take & (arm_q == ARM_MOUSE);

  always_comb begin
    case (act)
      ACT_RD_PINS: cap_byte = {kb_inhibit_in, 5'b0, ms_data_in, kb_data_in};
      ACT_RD_PORT: cap_byte = port_q;
      ACT_RD_CLKS: cap_byte = {6'b0, ms_clk_in, kb_clk_in};
      default:     cap_byte = '0;
    endcase
  end

  always_comb begin
    arm_n    = arm_q;
    port_n   = port_q;
    state_en = cmd_take | dat_take;
    if (cmd_take) begin
      case (act)
        ACT_ARM_PORT:  arm_n = ARM_PORT;
        ACT_ARM_MOUSE: arm_n = ARM_MOUSE;
        default:       arm_n = ARM_NONE;   // any other command cancels a pending byte
      endcase
    end else if (dat_take) begin
      arm_n = ARM_NONE;
      if (arm_q == ARM_PORT) port_n = host_wdata & PORT_LIVE;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      arm_q  <= ARM_NONE;
      port_q <= PORT_RST;
    end else if (state_en) begin
      arm_q  <= arm_n;
      port_q <= port_n;
    end
  end

  kbc_read_stage #(.DW(BYTE_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .capture  (rd_capture),
    .cap_data (cap_byte),
    .obf_full (obf_full),
    .pending  (rd_pending),
    .ob_load  (ob_load),
    .ob_data  (ob_data)
  );

  kbc_pulse_timer #(.PULSE_CYC(PULSE_CYC), .NB(PULSE_W)) u_pulse (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .start     (pulse_start),
    .start_sel (pulse_sel),
    .active    (pulse_active),
    .low_sel   (low_sel)
  );

  kbc_mouse_fwd #(.DW(BYTE_W)) u_ms (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .send      (ms_send),
    .send_data (host_wdata),
    .tx_done   (ms_tx_done),
    .tx_req    (ms_tx_req),
    .tx_data   (ms_tx_data)
  );

  for (genvar i = 0; i < BYTE_W; i++) begin : g_port
    if (i < PULSE_W) begin : g_pulsed
      assign out_port[i] = port_q[i] & ~low_sel[i];
    end else begin : g_plain
      assign out_port[i] = port_q[i];
    end
  end

endmodule

// File: rtl/kbc_cmd_engine_chk.sv
`timescale 1ns/1ps
module kbc_cmd_engine_chk #(
  parameter int unsigned PULSE_CYC = 1500
) (
  input logic       clk,
  input logic       rst_n,
  input logic       host_wr,
  input logic       host_is_cmd,
  input logic [7:0] host_wdata,
  input logic       obf_full,
  input logic       ob_load,
  input logic [7:0] out_port,
  input logic       ms_tx_req,
  input logic [7:0] ms_tx_data,
  input logic       ms_tx_done,
  input logic       busy,
  input logic       pulse_active
);

  int unsigned act_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            act_cnt <= 0;
    else if (pulse_active) act_cnt <= act_cnt + 1;
    else                   act_cnt <= 0;
  end

  p_hold_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    obf_full |-> !ob_load);

  p_one_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ob_load |=> !ob_load);

  p_ms_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ms_tx_req && !ms_tx_done) |=> (ms_tx_req && $stable(ms_tx_data)));

  p_ms_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ms_tx_req |-> busy);

  p_pulse_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_active |-> busy);

  p_pulse_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_active) |-> (act_cnt == PULSE_CYC));

  p_noop_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_is_cmd && !busy && host_wdata[7:4] == 4'hF && host_wdata[1:0] == 2'b11)
      |=> (!busy && $stable(out_port)));

  p_dead_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_port & 8'hCC) == 8'h00);

endmodule

bind kbc_cmd_engine kbc_cmd_engine_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_wr      (host_wr),
  .host_is_cmd  (host_is_cmd),
  .host_wdata   (host_wdata),
  .obf_full     (obf_full),
  .ob_load      (ob_load),
  .out_port     (out_port),
  .ms_tx_req    (ms_tx_req),
  .ms_tx_data   (ms_tx_data),
  .ms_tx_done   (ms_tx_done),
  .busy         (busy),
  .pulse_active (pulse_active)
);

// File: tb/kbc_cmd_engine_tb.sv
`timescale 1ns/1ps
module kbc_cmd_engine_tb;

  localparam int PCYC = 1500;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0;
  logic       host_is_cmd = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic       obf_full = 1'b0;
  logic       kb_inhibit_in = 1'b0, kb_data_in = 1'b0, ms_data_in = 1'b0;
  logic       kb_clk_in = 1'b0, ms_clk_in = 1'b0;
  logic       ms_tx_done = 1'b0;
  logic       ob_load, ms_tx_req, busy;
  logic [7:0] ob_data, out_port, ms_tx_data;

  int    checks = 0;
  int    fails = 0;
  int    cyc = 0;
  bit    cmp_en = 1'b0;
  string cur_req = "R12";

  always #2 clk = ~clk;

  kbc_cmd_engine #(.PULSE_CYC(PCYC), .OUTP_INIT(8'h03)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_is_cmd(host_is_cmd),
    .host_wdata(host_wdata), .obf_full(obf_full), .ob_load(ob_load), .ob_data(ob_data),
    .kb_inhibit_in(kb_inhibit_in), .kb_data_in(kb_data_in), .ms_data_in(ms_data_in),
    .kb_clk_in(kb_clk_in), .ms_clk_in(ms_clk_in), .out_port(out_port),
    .ms_tx_req(ms_tx_req), .ms_tx_data(ms_tx_data), .ms_tx_done(ms_tx_done), .busy(busy)
  );

  // ---------------- behavioural reference ----------------
  int         m_arm;      // 0 none, 1 port write, 2 mouse
  logic [7:0] m_port;
  bit         m_rd;
  logic [7:0] m_rd_byte;
  int         m_left;
  logic [1:0] m_mask;
  bit         m_ms;
  logic [7:0] m_ms_byte;

  always @(posedge clk) begin
    bit m_busy;
    if (!rst_n) begin
      m_arm = 0; m_port = 8'h03; m_rd = 0; m_rd_byte = 0;
      m_left = 0; m_mask = 0; m_ms = 0; m_ms_byte = 0;
    end else begin
      m_busy = m_rd || (m_left > 0) || m_ms;
      if (m_rd && !obf_full) m_rd = 0;
      if (m_left > 0) begin
        m_left--;
        if (m_left == 0) m_mask = 0;
      end
      if (m_ms && ms_tx_done) m_ms = 0;
      if (host_wr && !m_busy) begin
        if (host_is_cmd) begin
          m_arm = 0;
          if (host_wdata == 8'hC0) begin
            m_rd = 1; m_rd_byte = {kb_inhibit_in, 5'b0, ms_data_in, kb_data_in};
          end else if (host_wdata == 8'hD0) begin
            m_rd = 1; m_rd_byte = m_port;
          end else if (host_wdata == 8'hE0) begin
            m_rd = 1; m_rd_byte = {6'b0, ms_clk_in, kb_clk_in};
          end else if (host_wdata == 8'hD1) m_arm = 1;
          else if (host_wdata == 8'hD4) m_arm = 2;
          else if (host_wdata[7:4] == 4'hF && host_wdata[1:0] != 2'b11) begin
            m_mask = ~host_wdata[1:0];
            m_left = PCYC;
          end
        end else begin
          if (m_arm == 1) m_port = host_wdata & 8'h33;
          else if (m_arm == 2) begin m_ms = 1; m_ms_byte = host_wdata; end
          m_arm = 0;
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      logic [7:0] e_out;
      logic       e_load;
      e_out  = m_port & ~{6'b0, m_mask};
      e_load = m_rd && !obf_full;
      chk(cur_req, "out_port", out_port, e_out);
      chk(cur_req, "busy", {7'b0, busy}, {7'b0, (m_rd || m_left > 0 || m_ms)});
      chk(cur_req, "ob_load", {7'b0, ob_load}, {7'b0, e_load});
      if (e_load) chk(cur_req, "ob_data", ob_data, m_rd_byte);
      chk(cur_req, "ms_tx_req", {7'b0, ms_tx_req}, {7'b0, m_ms});
      if (m_ms) chk(cur_req, "ms_tx_data", ms_tx_data, m_ms_byte);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic is_cmd, input logic [7:0] b);
    @(posedge clk); #1;
    host_wr = 1'b1; host_is_cmd = is_cmd; host_wdata = b;
    @(posedge clk); #1;
    host_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_free();
    for (int k = 0; k < 4000 && busy; k++) @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog all-requirements actual=%0d expected<=%0d", cyc, 100000);
      summary();
    end
  end

  initial begin
    int n;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    cmp_en = 1'b1;

    // R12 reset state
    @(negedge clk);
    chk("R12", "out_port", out_port, 8'h03);
    chk("R12", "busy", {7'b0, busy}, 8'h00);
    chk("R12", "ob_load", {7'b0, ob_load}, 8'h00);
    chk("R12", "ms_tx_req", {7'b0, ms_tx_req}, 8'h00);

    // R7 pulse on bit 0, measured width
    cur_req = "R7";
    wr(1, 8'hF2);
    @(negedge clk);
    chk("R7", "out_port pulse bit0", out_port, 8'h02);
    n = 0;
    while (busy && n < 5000) begin
      if (!out_port[0]) n++;
      @(negedge clk);
    end
    chk("R7", "pulse width lo", n[7:0], PCYC[7:0]);
    chk("R7", "pulse width hi", n[15:8], PCYC[15:8]);
    chk("R7", "out_port after", out_port, 8'h03);
    wr(1, 8'hF0);
    @(negedge clk);
    chk("R7", "out_port both low", out_port, 8'h00);
    wait_free();

    // R11 writes during a pulse are dropped
    cur_req = "R11";
    wr(1, 8'hF1);
    wr(1, 8'hD1);
    wait_free();
    wr(0, 8'h00);
    @(negedge clk);
    chk("R11", "out_port", out_port, 8'h03);

    // R8 no-pulse opcodes
    cur_req = "R8";
    wr(1, 8'hFF);
    @(negedge clk);
    chk("R8", "busy FF", {7'b0, busy}, 8'h00);
    wr(1, 8'hF3);
    @(negedge clk);
    chk("R8", "busy F3", {7'b0, busy}, 8'h00);
    chk("R8", "out_port", out_port, 8'h03);

    // R1 pin read
    cur_req = "R1";
    kb_inhibit_in = 1; ms_data_in = 0; kb_data_in = 1;
    wr(1, 8'hC0);
    @(negedge clk);
    chk("R1", "ob_load", {7'b0, ob_load}, 8'h01);
    chk("R1", "ob_data", ob_data, 8'h81);
    kb_inhibit_in = 0; ms_data_in = 1; kb_data_in = 0;
    wr(1, 8'hC0);
    @(negedge clk);
    chk("R1", "ob_data", ob_data, 8'h02);

    // R3 clock-line read
    cur_req = "R3";
    ms_clk_in = 1; kb_clk_in = 0;
    wr(1, 8'hE0);
    @(negedge clk);
    chk("R3", "ob_data", ob_data, 8'h02);
    ms_clk_in = 0; kb_clk_in = 1;
    wr(1, 8'hE0);
    @(negedge clk);
    chk("R3", "ob_data", ob_data, 8'h01);

    // R5 / R2 port write and read back
    cur_req = "R5";
    wr(1, 8'hD1); wr(0, 8'hFF);
    @(negedge clk);
    chk("R5", "out_port", out_port, 8'h33);
    cur_req = "R2";
    wr(1, 8'hD0);
    @(negedge clk);
    chk("R2", "ob_data", ob_data, 8'h33);
    cur_req = "R5";
    wr(1, 8'hD1); wr(0, 8'hCC);
    @(negedge clk);
    chk("R5", "out_port", out_port, 8'h00);
    wr(1, 8'hD1); wr(0, 8'h12);
    cur_req = "R2";
    wr(1, 8'hD0);
    @(negedge clk);
    chk("R2", "ob_data", ob_data, 8'h12);
    wr(1, 8'hD1); wr(0, 8'h03);

    // R6 mouse forward
    cur_req = "R6";
    wr(1, 8'hD4); wr(0, 8'hA5);
    @(negedge clk);
    chk("R6", "ms_tx_req", {7'b0, ms_tx_req}, 8'h01);
    chk("R6", "ms_tx_data", ms_tx_data, 8'hA5);
    idle(3);
    @(negedge clk);
    chk("R6", "busy held", {7'b0, busy}, 8'h01);
    @(posedge clk); #1; ms_tx_done = 1'b1;
    @(posedge clk); #1; ms_tx_done = 1'b0;
    @(negedge clk);
    chk("R6", "ms_tx_req cleared", {7'b0, ms_tx_req}, 8'h00);

    // R9 cancel pending byte
    cur_req = "R9";
    wr(1, 8'hD1); wr(1, 8'hC0); wr(0, 8'h00);
    @(negedge clk);
    chk("R9", "out_port", out_port, 8'h03);
    wr(1, 8'hD4); wr(1, 8'hD0); wr(0, 8'h5A);
    @(negedge clk);
    chk("R9", "ms_tx_req", {7'b0, ms_tx_req}, 8'h00);

    // R10 unknown opcode and stray data
    cur_req = "R10";
    wr(1, 8'h55);
    @(negedge clk);
    chk("R10", "ob_load", {7'b0, ob_load}, 8'h00);
    wr(0, 8'h00);
    @(negedge clk);
    chk("R10", "out_port", out_port, 8'h03);
    wr(1, 8'hD1); wr(1, 8'h55); wr(0, 8'h00);
    @(negedge clk);
    chk("R10", "out_port", out_port, 8'h03);

    // R4 full buffer holds the result
    cur_req = "R4";
    obf_full = 1'b1;
    ms_clk_in = 1; kb_clk_in = 1;
    wr(1, 8'hE0);
    wr(1, 8'hD1);
    idle(4);
    @(negedge clk);
    chk("R4", "ob_load held", {7'b0, ob_load}, 8'h00);
    chk("R4", "busy", {7'b0, busy}, 8'h01);
    @(posedge clk); #1; obf_full = 1'b0;
    @(negedge clk);
    chk("R4", "ob_load", {7'b0, ob_load}, 8'h01);
    chk("R4", "ob_data", ob_data, 8'h03);
    wr(0, 8'h00);
    @(negedge clk);
    chk("R11", "out_port", out_port, 8'h03);

    idle(4);
    summary();
  end

endmodule